// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits in the command path of a controller for a 16-bit, four-bank synchronous DRAM. It turns one read or write command into the column address for each beat of the burst. It also produces the data-path strobes that go with those beats: a read-data-valid pulse delayed by the CAS latency, an output enable that honours the two-clock read mask delay, and a write mask that acts in the same cycle as the mask input. It holds no storage array. Refresh, bank timing and power-up sequencing belong to other blocks.

A command captures the start column and the burst settings (length, order, single-beat write mode). Columns then come out one per clock, starting the cycle after the command. A sequential burst counts upward and wraps inside the aligned group of the burst length. An interleaved burst XORs the beat number into the low column bits. A full-page burst runs modulo 256 until it is stopped or replaced. A new command is taken on any clock, so a command during a burst restarts the sequence.

The controller is a three-state machine. IDLE issues no beat. READ issues read beats and WRITE issues write beats. The transitions are:
- IDLE goes to READ on a read command, or to WRITE on a write command.
- READ and WRITE go to READ or WRITE on any new command, which restarts the burst.
- READ and WRITE return to IDLE after their last beat, or on a stop request when no command is present.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released with no command, col_valid, rd_valid, dq_oe and wr_mask are all 0.
- R2: A command sampled on a clock edge produces its first beat in the following cycle, with col_idx equal to the start_col sampled with the command. If rd_req and wr_req are both high, the read wins (col_is_wr = 0). A command also replaces any burst in progress.
- R3: blen_code selects the burst length: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. A non-full burst gives exactly that many consecutive beats and then col_valid drops.
- R4: With btype = 0, beat i of a burst of length L has column (start − start mod L) + ((start mod L + i) mod L).
- R5: With btype = 1 and length 2 to 8, beat i has column (start − start mod L) + ((start mod L) XOR i). With btype = 1 and full page, the order is sequential.
- R6: A full-page burst gives column (start + i) mod 256 on beat i and does not end by itself.
- R7: When wr_single = 1, every write burst has one beat, while reads keep the programmed length.
- R8: A stop_req with no command in the same cycle ends an active burst, so no beat appears in the next cycle. A command in the same cycle as stop_req takes precedence, and a stop_req while idle has no effect.
- R9: cas_lat encodes the latency in clocks (1, 2, 3; value 0 acts as 1). For a read issued in cycle c, beat i raises rd_valid in cycle c + latency + i.
- R10: dq_oe is high exactly when rd_valid is high and dqm_in was not high two cycles earlier.
- R11: wr_mask is high exactly in a write-beat cycle in which dqm_in is high. The mask has no effect in idle or read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat | input | 2 | Read latency in clocks, held steady during reads |
| blen_code | input | 3 | Burst length code, captured with a command |
| btype | input | 1 | 0 sequential, 1 interleaved, captured with a command |
| wr_single | input | 1 | Forces single-beat writes, captured with a command |
| start_col | input | 8 | First column of the burst |
| rd_req | input | 1 | Read command strobe |
| wr_req | input | 1 | Write command strobe |
| stop_req | input | 1 | Burst stop strobe |
| dqm_in | input | 1 | Data mask input |
| col_valid | output | 1 | A beat is issued this cycle |
| col_is_wr | output | 1 | The current beat belongs to a write |
| col_idx | output | 8 | Column of the current beat |
| rd_valid | output | 1 | Read data for a beat arrives this cycle |
| dq_oe | output | 1 | Read data output enabled this cycle |
| wr_mask | output | 1 | Write data of this cycle is masked |

## Verification
The two events that collide are a stop request and a new command arriving on the same clock during a running burst. The bench provokes this in the third beat of an eight-beat read, raising stop_req together with a write command to a different column. It then expects the next cycle to carry the write column rather than an idle slot, followed by a clean end after one beat. A second collision places a read mask within the latency window of a read, so that rd_valid and the masked dq_oe must disagree in exactly one cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } seq_state_t;

    localparam int PAGE_COLS_W  = 8;
    localparam int DEF_MAX_CL   = 3;
    localparam int RD_MASK_LAT  = 2;
    localparam logic [2:0] BL_PAGE_CODE = 3'd7;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = PAGE_COLS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             stop_req,
    input  logic [2:0]       blen_code,
    input  logic             btype,
    input  logic             wr_single,
    input  logic [COL_W-1:0] start_col,
    output seq_state_t       state,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] beat_cnt,
    output logic [COL_W-1:0] grp_mask,
    output logic             ilv,
    output logic             full
);

    seq_state_t       state_n;
    logic [COL_W-1:0] base_n, beat_n, mask_n, code_mask;
    logic             ilv_n, full_n;
    logic             cmd, cmd_wr, one_beat_wr, last_beat;

    always_comb begin
        case (blen_code)
            3'd1:         code_mask = COL_W'(1);
            3'd2:         code_mask = COL_W'(3);
            3'd3:         code_mask = COL_W'(7);
            BL_PAGE_CODE: code_mask = '1;
            default:      code_mask = '0;
        endcase
    end

    assign cmd         = rd_req | wr_req;
    assign cmd_wr      = wr_req & ~rd_req;
    assign one_beat_wr = cmd_wr & wr_single;
    assign last_beat   = ~full & (beat_cnt == grp_mask);

    always_comb begin
        state_n = state;
        base_n  = base_col;
        beat_n  = beat_cnt;
        mask_n  = grp_mask;
        ilv_n   = ilv;
        full_n  = full;
        unique case (state)
            S_IDLE: state_n = S_IDLE;
            S_READ, S_WRITE: begin
                if (stop_req || last_beat) state_n = S_IDLE;
                else                       beat_n  = beat_cnt + 1'b1;
            end
            default: state_n = S_IDLE;
        endcase
        if (cmd) begin
            state_n = cmd_wr ? S_WRITE : S_READ;
            base_n  = start_col;
            beat_n  = '0;
            mask_n  = one_beat_wr ? '0 : code_mask;
            full_n  = (blen_code == BL_PAGE_CODE) && !one_beat_wr;
            ilv_n   = btype && (blen_code != BL_PAGE_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_col <= '0;
            beat_cnt <= '0;
            grp_mask <= '0;
            ilv      <= 1'b0;
            full     <= 1'b0;
        end else begin
            base_col <= base_n;
            beat_cnt <= beat_n;
            grp_mask <= mask_n;
            ilv      <= ilv_n;
            full     <= full_n;
        end
    end

endmodule

// File: rtl/bcs_colgen.sv
module bcs_colgen #(
    parameter int COL_W = bcs_pkg::PAGE_COLS_W
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] grp_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col_idx
);

    logic [COL_W-1:0] low_part;

    always_comb begin
        low_part = ilv ? (base_col ^ beat_cnt) : (base_col + beat_cnt);
        col_idx  = (base_col & ~grp_mask) | (low_part & grp_mask);
    end

endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
    import bcs_pkg::*;
#(
    parameter int MAX_CL = DEF_MAX_CL,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_t      state,
    input  logic [CL_W-1:0] cas_lat,
    input  logic            dqm_in,
    output logic            rd_valid,
    output logic            dq_oe,
    output logic            wr_mask
);

    logic [MAX_CL-1:0]      rd_tap;
    logic [RD_MASK_LAT-1:0] dqm_q;
    logic [CL_W-1:0]        cl_sel;

    assign rd_tap[0] = (state == S_READ);

    for (genvar g = 1; g < MAX_CL; g++) begin : g_rd_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_tap[g] <= 1'b0;
            else        rd_tap[g] <= rd_tap[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dqm_q <= '0;
        else        dqm_q <= {dqm_q[RD_MASK_LAT-2:0], dqm_in};
    end

    always_comb begin
        if (cas_lat == '0)                      cl_sel = '0;
        else if (int'(cas_lat) > MAX_CL)        cl_sel = CL_W'(MAX_CL - 1);
        else                                    cl_sel = cas_lat - 1'b1;
    end

    assign rd_valid = rd_tap[cl_sel];
    assign dq_oe    = rd_valid & ~dqm_q[RD_MASK_LAT-1];
    assign wr_mask  = (state == S_WRITE) & dqm_in;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = PAGE_COLS_W,
    parameter int MAX_CL = DEF_MAX_CL,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CL_W-1:0]  cas_lat,
    input  logic [2:0]       blen_code,
    input  logic             btype,
    input  logic             wr_single,
    input  logic [COL_W-1:0] start_col,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             stop_req,
    input  logic             dqm_in,
    output logic             col_valid,
    output logic             col_is_wr,
    output logic [COL_W-1:0] col_idx,
    output logic             rd_valid,
    output logic             dq_oe,
    output logic             wr_mask
);

    seq_state_t       state;
    logic [COL_W-1:0] base_col, beat_cnt, grp_mask;
    logic             ilv, full;

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .wr_req(wr_req), .stop_req(stop_req),
        .blen_code(blen_code), .btype(btype), .wr_single(wr_single),
        .start_col(start_col),
        .state(state), .base_col(base_col), .beat_cnt(beat_cnt),
        .grp_mask(grp_mask), .ilv(ilv), .full(full)
    );

    bcs_colgen #(.COL_W(COL_W)) u_colgen (
        .base_col(base_col), .beat_cnt(beat_cnt), .grp_mask(grp_mask),
        .ilv(ilv), .col_idx(col_idx)
    );

    bcs_dpath #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .state(state), .cas_lat(cas_lat),
        .dqm_in(dqm_in), .rd_valid(rd_valid), .dq_oe(dq_oe), .wr_mask(wr_mask)
    );

    assign col_valid = (state != S_IDLE);
    assign col_is_wr = (state == S_WRITE);

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int COL_W = 8,
    parameter int CL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CL_W-1:0]  cas_lat,
    input logic             wr_single,
    input logic [COL_W-1:0] start_col,
    input logic             rd_req,
    input logic             wr_req,
    input logic             stop_req,
    input logic             dqm_in,
    input logic             col_valid,
    input logic             col_is_wr,
    input logic [COL_W-1:0] col_idx,
    input logic             rd_valid,
    input logic             dq_oe,
    input logic             wr_mask
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!col_valid && !rd_valid && !dq_oe && !wr_mask);
        end
    end

    // R2
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (col_valid && !col_is_wr && col_idx == $past(start_col)));

    // R7
    single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && wr_single) ##1 (!rd_req && !wr_req) |=> !col_valid);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop_req && !rd_req && !wr_req) |=> !col_valid);

    // R10
    rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dqm_in, 2) |-> !dq_oe);

    // R10
    oe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> rd_valid);

    // R11
    wr_mask_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask == (col_valid && col_is_wr && dqm_in));

endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .CL_W(CL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .wr_single(wr_single),
    .start_col(start_col), .rd_req(rd_req), .wr_req(wr_req),
    .stop_req(stop_req), .dqm_in(dqm_in), .col_valid(col_valid),
    .col_is_wr(col_is_wr), .col_idx(col_idx), .rd_valid(rd_valid),
    .dq_oe(dq_oe), .wr_mask(wr_mask)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cas_lat;
    logic [2:0] blen_code;
    logic       btype, wr_single;
    logic [7:0] start_col;
    logic       rd_req, wr_req, stop_req, dqm_in;
    logic       col_valid, col_is_wr, rd_valid, dq_oe, wr_mask;
    logic [7:0] col_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .blen_code(blen_code),
        .btype(btype), .wr_single(wr_single), .start_col(start_col),
        .rd_req(rd_req), .wr_req(wr_req), .stop_req(stop_req), .dqm_in(dqm_in),
        .col_valid(col_valid), .col_is_wr(col_is_wr), .col_idx(col_idx),
        .rd_valid(rd_valid), .dq_oe(dq_oe), .wr_mask(wr_mask)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(int start, int i, int len, bit ilv, bit full);
        int base, off;
        if (full) return (start + i) % 256;
        base = start - (start % len);
        off  = ilv ? ((start % len) ^ i) : (((start % len) + i) % len);
        return base + off;
    endfunction

    task automatic run_burst(input bit is_rd, input int code, input bit bt,
                             input bit wsb, input int start);
        int    len, n, e;
        bit    full;
        string tag;
        full = (code == 7);
        len  = full ? 256 : (1 << code);
        if (!is_rd && wsb) begin len = 1; full = 1'b0; end
        n = full ? 260 : len;
        if (full)                  tag = "R6";
        else if (!is_rd && wsb)    tag = "R7";
        else if (bt)               tag = "R5";
        else                       tag = "R4";
        rd_req = is_rd; wr_req = !is_rd; start_col = 8'(start);
        blen_code = 3'(code); btype = bt; wr_single = wsb;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (full && i == n - 1) stop_req = 1'b1;
            #1;
            chk(col_valid && (col_is_wr == !is_rd), tag, {col_valid, col_is_wr}, {1'b1, !is_rd});
            e = exp_col(start, i, len, bt && !full, full);
            chk(int'(col_idx) == e, tag, col_idx, e);
            @(negedge clk);
            stop_req = 1'b0;
        end
        #1;
        // R3 burst ends after its length (R8 for the stopped full page)
        chk(!col_valid, full ? "R8" : "R3", col_valid, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic lat_test(input int cl, input bit with_dqm);
        bit ev, eoe;
        cas_lat = 2'(cl); rd_req = 1'b1; blen_code = 3'd2; btype = 1'b0;
        wr_single = 1'b0; start_col = 8'h00;
        #1 chk(!rd_valid, "R9", rd_valid, 0);
        @(negedge clk);
        rd_req = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            dqm_in = with_dqm && (k == 2);
            #1;
            ev = (k >= (cl == 0 ? 1 : cl)) && (k <= (cl == 0 ? 1 : cl) + 3);
            chk(rd_valid == ev, "R9", rd_valid, ev);
            eoe = ev && !(with_dqm && k == 4);
            chk(dq_oe == eoe, "R10", dq_oe, eoe);
            chk(!wr_mask, "R11", wr_mask, 0);
            @(negedge clk);
        end
        dqm_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cas_lat = 2'd1; blen_code = 3'd0; btype = 1'b0;
        wr_single = 1'b0; start_col = 8'h00; rd_req = 1'b0; wr_req = 1'b0;
        stop_req = 1'b0; dqm_in = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 during reset
        chk(!col_valid && !rd_valid && !dq_oe && !wr_mask, "R1",
            {col_valid, rd_valid, dq_oe, wr_mask}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!col_valid && !rd_valid && !dq_oe && !wr_mask, "R1",
            {col_valid, rd_valid, dq_oe, wr_mask}, 0);
        @(negedge clk);

        // R3 R4 R5 R6: sweep lengths, orders, starts, directions
        for (int bt = 0; bt < 2; bt++)
            for (int ci = 0; ci < 5; ci++)
                for (int si = 0; si < 4; si++)
                    for (int rd = 0; rd < 2; rd++)
                        run_burst(rd[0], (ci == 4) ? 7 : ci, bt[0], 1'b0,
                                  (si == 0) ? 0 : (si == 1) ? 5 : (si == 2) ? 8'h37 : 8'hFE);

        // R7 single-beat writes, reads keep their length
        run_burst(1'b0, 2, 1'b0, 1'b1, 8'h13);
        run_burst(1'b0, 7, 1'b0, 1'b1, 8'hF0);
        run_burst(1'b0, 3, 1'b1, 1'b1, 8'h2A);
        run_burst(1'b1, 2, 1'b0, 1'b1, 8'h13);
        run_burst(1'b1, 3, 1'b1, 1'b1, 8'h2A);

        // R9 R10 read latency and read mask
        lat_test(0, 1'b0);
        lat_test(1, 1'b0);
        lat_test(2, 1'b1);
        lat_test(3, 1'b0);

        // R11 write mask in the same cycle
        wr_req = 1'b1; blen_code = 3'd2; btype = 1'b0; wr_single = 1'b0;
        start_col = 8'h20; dqm_in = 1'b1;
        #1 chk(!wr_mask, "R11", wr_mask, 0);
        @(negedge clk);
        wr_req = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            dqm_in = (k == 2) || (k == 5);
            #1;
            chk(wr_mask == (k == 2), "R11", wr_mask, (k == 2));
            @(negedge clk);
        end
        dqm_in = 1'b0;
        repeat (2) @(negedge clk);

        // R2 read wins over write in the same cycle
        rd_req = 1'b1; wr_req = 1'b1; blen_code = 3'd0; start_col = 8'h55;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        #1 chk(col_valid && !col_is_wr && col_idx == 8'h55, "R2",
               {col_valid, col_is_wr, col_idx}, {1'b1, 1'b0, 8'h55});
        repeat (3) @(negedge clk);

        // R8 stop and command in the same cycle: command wins
        rd_req = 1'b1; blen_code = 3'd3; btype = 1'b0; start_col = 8'h10;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        stop_req = 1'b1; wr_req = 1'b1; blen_code = 3'd0; start_col = 8'h40;
        #1 chk(col_valid && col_idx == 8'h12, "R4", col_idx, 8'h12);
        @(negedge clk);
        stop_req = 1'b0; wr_req = 1'b0;
        #1 chk(col_valid && col_is_wr && col_idx == 8'h40, "R8",
               {col_valid, col_is_wr, col_idx}, {1'b1, 1'b1, 8'h40});
        @(negedge clk);
        #1 chk(!col_valid, "R3", col_valid, 0);
        repeat (3) @(negedge clk);

        // R8 stop while idle has no effect
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        #1 chk(!col_valid, "R8", col_valid, 0);
        @(negedge clk);

        // R2 new command replaces a running burst
        rd_req = 1'b1; blen_code = 3'd3; start_col = 8'h20;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        rd_req = 1'b1; blen_code = 3'd1; start_col = 8'h80;
        #1 chk(col_valid && col_idx == 8'h21, "R2", col_idx, 8'h21);
        @(negedge clk);
        rd_req = 1'b0;
        #1 chk(col_valid && col_idx == 8'h80, "R2", col_idx, 8'h80);
        @(negedge clk);
        #1 chk(col_valid && col_idx == 8'h81, "R2", col_idx, 8'h81);
        @(negedge clk);
        #1 chk(!col_valid, "R2", col_valid, 0);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule